// File: doc/BRIEF.md
# Exclusive Access Monitor

This block sits in front of a small word-addressed memory that several requesters use for lock variables. Each requester can issue four kinds of request: plain read, plain write, reserving read (load-exclusive) and conditional write (store-exclusive). Every requester has its own two-state monitor. A reserving read returns the word, arms that requester's monitor and records the word's address. A conditional write only updates memory while that monitor is still armed for the same address. Its one-bit status tells software whether the lock was taken.

The block accepts a request from every requester on every cycle. Any write that commits disarms the other requesters' monitors that hold the written address. When several writes target one address in the same cycle, a fixed priority lets the lowest-numbered requester win. A requester whose conditional write loses or fails never writes memory, so a single reservation round hands a lock to at most one requester. Read data and status come back exactly one clock after the request, together with a per-requester valid strobe.

Top module: `excl_mon_top`

## Requirements
- R1: After reset every monitor is disarmed, every memory word is zero and no response strobe is active, so a conditional write issued before any reserving read fails.
- R2: A reserving read (op code 2'b10) returns the addressed word, arms the requester's monitor and records that address.
- R3: A conditional write (op code 2'b11) from an armed requester to its recorded address commits its data to memory and disarms the monitor, so a second conditional write without a new reserving read fails.
- R4: The status bit `rsp_xfail` is 0 for a conditional write that committed and 1 for one that did not. It is 0 for every other op code.
- R5: A conditional write from a disarmed requester fails and leaves memory unchanged.
- R6: A conditional write to an address other than the recorded one fails, leaves memory unchanged and disarms the monitor.
- R7: A committed write (plain, op code 2'b01, or conditional) by one requester to an address recorded by another armed requester disarms that other requester's monitor.
- R8: When more than one requester would commit a write to the same address in one cycle, only the lowest-numbered of them commits. The others do not write, and a losing conditional write reports status 1. A conditional write that fails for its own reasons blocks no one.
- R9: A reserving read issued in the same cycle that another requester commits a write to that address returns the old word but leaves the monitor disarmed.
- R10: A plain read (op code 2'b00) and a requester's own plain write leave that requester's monitor state and recorded address unchanged.
- R11: For every request accepted in a cycle, `rsp_valid` for that requester is high in the next cycle and low otherwise. Read data for op codes 2'b00 and 2'b10 and status appear in that same next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | NREQ | Request present, one bit per requester |
| req_op | input | NREQ x 2 | Op code: 00 read, 01 write, 10 reserving read, 11 conditional write |
| req_addr | input | NREQ x AW | Word address per requester |
| req_wdata | input | NREQ x DW | Write data per requester |
| rsp_valid | output | NREQ | Response strobe, one cycle after the request |
| rsp_rdata | output | NREQ x DW | Read data for read-type requests |
| rsp_xfail | output | NREQ | Conditional write status: 0 committed, 1 failed |

## Verification
Two functions can meet in the same cycle: one requester's committing write and another requester's reservation traffic (a reserving read or a conditional write) on the same address. Directed cycles pair a plain write with a reserving read. They also race conditional writes from two armed requesters, including the case where the lower-numbered one is already disarmed. A long random phase restricts all requesters to four addresses so that such collisions happen often. A behavioural reference model in the bench judges each cycle by comparing strobes, status bits and read data. The read data later shows which write, if any, reached memory.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  typedef enum logic [1:0] {
    OP_LD  = 2'b00,
    OP_ST  = 2'b01,
    OP_LDX = 2'b10,
    OP_STX = 2'b11
  } op_e;

  typedef enum logic {
    MON_OPEN = 1'b0,
    MON_EXCL = 1'b1
  } mon_e;
endpackage

// File: rtl/excl_mon_arb.sv
module excl_mon_arb
  import excl_mon_pkg::*;
#(
  parameter int NREQ = 3,
  parameter int AW   = 3
) (
  input  logic [NREQ-1:0]         req_valid,
  input  logic [NREQ-1:0][1:0]    req_op,
  input  logic [NREQ-1:0][AW-1:0] req_addr,
  input  logic [NREQ-1:0]         mon_excl,
  input  logic [NREQ-1:0][AW-1:0] mon_addr,
  output logic [NREQ-1:0]         commit,
  output logic [NREQ-1:0]         stx_fail,
  output logic [NREQ-1:0]         snoop_mon,
  output logic [NREQ-1:0]         snoop_req
);

  logic [NREQ-1:0] want;
  logic [NREQ-1:0] is_stx;

  // Fixed priority: a lower-numbered committed write to the same word blocks.
  always_comb begin
    for (int i = 0; i < NREQ; i++) begin
      is_stx[i] = req_valid[i] && (op_e'(req_op[i]) == OP_STX);
      want[i]   = (req_valid[i] && (op_e'(req_op[i]) == OP_ST)) ||
                  (is_stx[i] && mon_excl[i] && (mon_addr[i] == req_addr[i]));
    end
    for (int i = 0; i < NREQ; i++) begin
      commit[i] = want[i];
      for (int j = 0; j < i; j++) begin
        if (commit[j] && (req_addr[j] == req_addr[i])) commit[i] = 1'b0;
      end
      stx_fail[i] = is_stx[i] && !commit[i];
    end
  end

  // Snoop: committed writes of other requesters against reserved / requested words.
  always_comb begin
    for (int i = 0; i < NREQ; i++) begin
      snoop_mon[i] = 1'b0;
      snoop_req[i] = 1'b0;
      for (int j = 0; j < NREQ; j++) begin
        if (j != i && commit[j]) begin
          if (req_addr[j] == mon_addr[i]) snoop_mon[i] = 1'b1;
          if (req_addr[j] == req_addr[i]) snoop_req[i] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/excl_mon_fsm.sv
module excl_mon_fsm
  import excl_mon_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic          snoop_mon,
  input  logic          snoop_req,
  output logic          mon_excl,
  output logic [AW-1:0] mon_addr
);

  mon_e          state_q, state_d;
  logic [AW-1:0] addr_q;
  logic          addr_en;

  always_comb begin
    state_d = state_q;
    addr_en = 1'b0;
    if (req_valid && (op_e'(req_op) == OP_LDX)) begin
      addr_en = 1'b1;
      state_d = snoop_req ? MON_OPEN : MON_EXCL;
    end else if (req_valid && (op_e'(req_op) == OP_STX)) begin
      state_d = MON_OPEN;
    end else if (snoop_mon) begin
      state_d = MON_OPEN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MON_OPEN;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (addr_en) addr_q <= req_addr;
    end
  end

  assign mon_excl = (state_q == MON_EXCL);
  assign mon_addr = addr_q;

endmodule

// File: rtl/excl_mon_mem.sv
module excl_mon_mem #(
  parameter int NREQ = 3,
  parameter int AW   = 3,
  parameter int DW   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NREQ-1:0]         wr_en,
  input  logic [NREQ-1:0]         rd_en,
  input  logic [NREQ-1:0][AW-1:0] addr,
  input  logic [NREQ-1:0][DW-1:0] wdata,
  output logic [NREQ-1:0][DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0][DW-1:0] mem_q, mem_d;
  logic [NREQ-1:0][DW-1:0]  rd_q;

  // Writes to one word are mutually exclusive (arbiter guarantee).
  always_comb begin
    mem_d = mem_q;
    for (int i = 0; i < NREQ; i++) begin
      if (wr_en[i]) mem_d[addr[i]] = wdata[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else        mem_q <= mem_d;
  end

  for (genvar g = 0; g < NREQ; g++) begin : g_rd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rd_q[g] <= '0;
      else if (rd_en[g]) rd_q[g] <= mem_q[addr[g]];
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/excl_mon_top.sv
module excl_mon_top
  import excl_mon_pkg::*;
#(
  parameter int NREQ = 3,
  parameter int AW   = 3,
  parameter int DW   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NREQ-1:0]         req_valid,
  input  logic [NREQ-1:0][1:0]    req_op,
  input  logic [NREQ-1:0][AW-1:0] req_addr,
  input  logic [NREQ-1:0][DW-1:0] req_wdata,
  output logic [NREQ-1:0]         rsp_valid,
  output logic [NREQ-1:0][DW-1:0] rsp_rdata,
  output logic [NREQ-1:0]         rsp_xfail
);

  logic [NREQ-1:0]         mon_excl_w;
  logic [NREQ-1:0][AW-1:0] mon_addr_w;
  logic [NREQ-1:0]         commit_w;
  logic [NREQ-1:0]         stx_fail_w;
  logic [NREQ-1:0]         snoop_mon_w;
  logic [NREQ-1:0]         snoop_req_w;
  logic [NREQ-1:0]         rd_en_w;
  logic [NREQ-1:0]         valid_q;
  logic [NREQ-1:0]         xfail_q;

  excl_mon_arb #(.NREQ(NREQ), .AW(AW)) u_arb (
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .mon_excl  (mon_excl_w),
    .mon_addr  (mon_addr_w),
    .commit    (commit_w),
    .stx_fail  (stx_fail_w),
    .snoop_mon (snoop_mon_w),
    .snoop_req (snoop_req_w)
  );

  for (genvar g = 0; g < NREQ; g++) begin : g_mon
    excl_mon_fsm #(.AW(AW)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid[g]),
      .req_op    (req_op[g]),
      .req_addr  (req_addr[g]),
      .snoop_mon (snoop_mon_w[g]),
      .snoop_req (snoop_req_w[g]),
      .mon_excl  (mon_excl_w[g]),
      .mon_addr  (mon_addr_w[g])
    );
    assign rd_en_w[g] = req_valid[g] && !req_op[g][0];
  end

  excl_mon_mem #(.NREQ(NREQ), .AW(AW), .DW(DW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (commit_w),
    .rd_en   (rd_en_w),
    .addr    (req_addr),
    .wdata   (req_wdata),
    .rd_data (rsp_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      xfail_q <= '0;
    end else begin
      valid_q <= req_valid;
      xfail_q <= stx_fail_w;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_xfail = xfail_q;

endmodule

// File: rtl/excl_mon_chk.sv
module excl_mon_chk
  import excl_mon_pkg::*;
#(
  parameter int NREQ = 3,
  parameter int AW   = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NREQ-1:0]         req_valid,
  input logic [NREQ-1:0][1:0]    req_op,
  input logic [NREQ-1:0][AW-1:0] req_addr,
  input logic [NREQ-1:0]         rsp_valid,
  input logic [NREQ-1:0]         rsp_xfail,
  input logic [NREQ-1:0]         mon_excl,
  input logic [NREQ-1:0][AW-1:0] mon_addr,
  input logic [NREQ-1:0]         commit,
  input logic [NREQ-1:0]         snoop_mon,
  input logic [NREQ-1:0]         snoop_req
);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_state_r1: assert (mon_excl == '0 && rsp_valid == '0);
    end
  end

  for (genvar g = 0; g < NREQ; g++) begin : g_req
    p_ldx_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[g] && op_e'(req_op[g]) == OP_LDX && !snoop_req[g])
      |=> (mon_excl[g] && mon_addr[g] == $past(req_addr[g])));

    p_stx_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (commit[g] && op_e'(req_op[g]) == OP_STX) |=> (!rsp_xfail[g] && !mon_excl[g]));

    p_fail_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[g] && op_e'(req_op[g]) == OP_STX && !commit[g]) |=> rsp_xfail[g]);

    p_other_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid[g] && op_e'(req_op[g]) == OP_STX) |=> !rsp_xfail[g]);

    p_open_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[g] && op_e'(req_op[g]) == OP_STX && !mon_excl[g]) |-> !commit[g]);

    p_addr_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[g] && op_e'(req_op[g]) == OP_STX && mon_addr[g] != req_addr[g])
      |-> !commit[g]);

    p_snoop_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!(req_valid[g] && req_op[g][1]) && snoop_mon[g]) |=> !mon_excl[g]);

    p_ldx_killed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[g] && op_e'(req_op[g]) == OP_LDX && snoop_req[g]) |=> !mon_excl[g]);

    p_load_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[g] && op_e'(req_op[g]) == OP_LD && !snoop_mon[g])
      |=> ($stable(mon_excl[g]) && $stable(mon_addr[g])));

    p_strobe_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[g] |=> rsp_valid[g]);

    p_strobe_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid[g] |=> !rsp_valid[g]);

    for (genvar h = g + 1; h < NREQ; h++) begin : g_pair
      p_one_winner_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit[g] && commit[h] && req_addr[g] == req_addr[h]));
    end
  end

endmodule

bind excl_mon_top excl_mon_chk #(.NREQ(NREQ), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_xfail (rsp_xfail),
  .mon_excl  (mon_excl_w),
  .mon_addr  (mon_addr_w),
  .commit    (commit_w),
  .snoop_mon (snoop_mon_w),
  .snoop_req (snoop_req_w)
);

// File: tb/excl_mon_top_tb_top.sv
`timescale 1ns/1ps
module excl_mon_top_tb_top;

  localparam int N  = 3;
  localparam int AW = 3;
  localparam int DW = 32;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]         req_valid = '0;
  logic [N-1:0][1:0]    req_op    = '0;
  logic [N-1:0][AW-1:0] req_addr  = '0;
  logic [N-1:0][DW-1:0] req_wdata = '0;
  logic [N-1:0]         rsp_valid;
  logic [N-1:0][DW-1:0] rsp_rdata;
  logic [N-1:0]         rsp_xfail;

  int checks = 0;
  int fails  = 0;

  // Reference model state
  logic [DW-1:0] m_mem  [DEPTH];
  bit            m_excl [N];
  int            m_addr [N];

  always #2.5 clk = ~clk;

  excl_mon_top #(.NREQ(N), .AW(AW), .DW(DW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_xfail (rsp_xfail)
  );

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic drv(int i, int op, int a, int d);
    req_valid[i] = 1'b1;
    req_op[i]    = 2'(op);
    req_addr[i]  = AW'(a);
    req_wdata[i] = DW'(d);
  endtask

  // One cycle: predict from model, clock, compare at the following negedge.
  task automatic step(string tag);
    bit            cm   [N];
    bit            e_ld [N];
    bit            e_fl [N];
    bit            e_v  [N];
    logic [DW-1:0] e_rd [N];
    bit            hreq [N];
    bit            hmon [N];
    for (int i = 0; i < N; i++) begin
      int  op = int'(req_op[i]);
      int  a  = int'(req_addr[i]);
      bit  v  = req_valid[i];
      bit  w  = (v && op == 1) || (v && op == 3 && m_excl[i] && m_addr[i] == a);
      for (int j = 0; j < i; j++)
        if (cm[j] && int'(req_addr[j]) == a) w = 1'b0;
      cm[i]   = w;
      e_v[i]  = v;
      e_fl[i] = v && op == 3 && !w;
      e_ld[i] = v && (op == 0 || op == 2);
      e_rd[i] = m_mem[a];
    end
    for (int i = 0; i < N; i++) begin
      hreq[i] = 1'b0;
      hmon[i] = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (j != i && cm[j] && int'(req_addr[j]) == int'(req_addr[i])) hreq[i] = 1'b1;
        if (j != i && cm[j] && int'(req_addr[j]) == m_addr[i]) hmon[i] = 1'b1;
      end
    end
    for (int i = 0; i < N; i++) begin
      if (req_valid[i] && req_op[i] == 2'b10) begin
        m_excl[i] = !hreq[i];
        m_addr[i] = int'(req_addr[i]);
      end else if (req_valid[i] && req_op[i] == 2'b11) begin
        m_excl[i] = 1'b0;
      end else if (hmon[i]) begin
        m_excl[i] = 1'b0;
      end
    end
    for (int i = 0; i < N; i++)
      if (cm[i]) m_mem[int'(req_addr[i])] = req_wdata[i];
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      check(tag, $sformatf("rsp_valid[%0d] (R11)", i), rsp_valid[i], e_v[i]);
      check(tag, $sformatf("rsp_xfail[%0d] (R4)", i), rsp_xfail[i], e_fl[i]);
      if (e_ld[i]) check(tag, $sformatf("rsp_rdata[%0d]", i), rsp_rdata[i], e_rd[i]);
    end
    req_valid = '0;
    req_op    = '0;
    req_addr  = '0;
    req_wdata = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int k = 0; k < DEPTH; k++) m_mem[k] = '0;
    for (int i = 0; i < N; i++) begin m_excl[i] = 1'b0; m_addr[i] = 0; end
    repeat (3) @(negedge clk);
    check("R1", "rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "rsp_valid after reset", rsp_valid, 0);

    // R1: conditional write before any reservation fails; memory is zero
    drv(0, 3, 1, 5); drv(1, 0, 1, 0); step("R1");
    drv(2, 0, 1, 0); step("R1");

    // R2: reserving read returns the word
    drv(2, 1, 1, 32'h11); step("R11");
    drv(0, 2, 1, 0); step("R2");

    // R3 / R5: conditional write passes once, then fails with memory unchanged
    drv(0, 3, 1, 32'h22); step("R3");
    drv(1, 0, 1, 0); step("R3");
    drv(0, 3, 1, 32'h33); step("R5");
    drv(1, 0, 1, 0); step("R5");

    // R6: wrong address fails and disarms
    drv(1, 2, 3, 0); step("R6");
    drv(1, 3, 4, 32'h44); step("R6");
    drv(1, 3, 3, 32'h45); step("R6");
    drv(0, 0, 4, 0); drv(2, 0, 3, 0); step("R6");

    // R7: another requester's plain write disarms
    drv(0, 2, 5, 0); step("R7");
    drv(1, 1, 5, 32'h55); step("R7");
    drv(0, 3, 5, 32'h56); step("R7");
    drv(2, 0, 5, 0); step("R7");

    // R8: racing conditional writes, lowest wins
    drv(0, 2, 6, 0); drv(2, 2, 6, 0); step("R8");
    drv(0, 3, 6, 32'h1); drv(2, 3, 6, 32'h2); step("R8");
    drv(1, 0, 6, 0); step("R8");
    // R8: a disarmed lower requester blocks no one
    drv(1, 2, 7, 0); drv(2, 2, 7, 0); step("R8");
    drv(0, 3, 7, 32'h7); drv(2, 3, 7, 32'h77); step("R8");
    drv(1, 3, 7, 32'h78); step("R8");
    drv(0, 0, 7, 0); step("R8");
    // R8: two plain writes to one word, lowest wins
    drv(1, 1, 2, 32'hA1); drv(2, 1, 2, 32'hA2); step("R8");
    drv(0, 0, 2, 0); step("R8");

    // R9: reservation taken in the cycle of a committing write is void
    drv(0, 1, 0, 32'h90); drv(1, 2, 0, 0); step("R9");
    drv(1, 3, 0, 32'h91); step("R9");
    drv(2, 0, 0, 0); step("R9");

    // R10: plain read and own plain write keep the reservation
    drv(2, 2, 4, 0); step("R10");
    drv(2, 0, 3, 0); step("R10");
    drv(2, 1, 4, 32'hB0); step("R10");
    drv(2, 3, 4, 32'hB1); step("R10");
    drv(0, 0, 4, 0); step("R10");

    // Random traffic on four words to provoke same-cycle collisions
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < N; i++)
        if ($urandom_range(0, 3) != 0)
          drv(i, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), int'($urandom));
      step("R8");
    end
    finish_run();
  end

endmodule